// File: doc/BRIEF.md
# Debug Port Bank-Select and Posted-Read Sequencer

This block sits on the host side of a serial-wire debug link. Above it is a request port that carries one register access at a time. Below it is a raw register-transaction port that feeds a bit-level wire engine. Each request names:

- the direction (read or write);
- the target, either the debug port (DP) or an access port (AP);
- a six-bit register index, where bits [1:0] select the word within a bank and bits [5:2] select the bank;
- write data;
- an AP number.

A request can also be an end-of-batch flush. The block expands each request into one to three raw transactions:

1. a collecting read of the read buffer, when an AP read result is still outstanding;
2. a write to the bank-selection register, when the wanted bank is not already known to be selected;
3. the access itself.

The block keeps a copy of the bank-selection register, called the select cache, so that it can leave out redundant selection writes. AP reads on the link are posted: each raw AP read returns the value fetched by the previous one. The block passes that value back with a flag and records that a newer result is still outstanding. A line-reset indication clears the cache. The DP bank field stays known as zero, so the identification register can be read straight after a reset.

Top module: `dpsel_sequencer`

## Requirements
- R1: A DP access is banked only when its word index is 1, or in the newer-architecture mode (`mode_v6`=1) when its word index is 0 or 1. A DP write to word 0 is never banked. No other DP access ever causes a selection write.
- R2: A DP selection write carries the request bank in bits [3:0] and keeps bits [31:4] from the cache.
- R3: An AP selection write carries the AP number in bits [31:24] and the request bank in bits [7:4], with zeros between. Bits [3:0] are kept from the cache.
- R4: A selection write is left out when the field it would set is known and already equal to the cached value.
- R5: A DP write to word 0 (the abort register) is never preceded by a selection write.
- R6: An AP read response returns the raw read data. `rsp_posted`=1 only if an earlier AP read was outstanding and this read ended OK. A DP read of word 3 (the read buffer) also collects and clears the outstanding result.
- R7: When an AP result is outstanding, a DP write, an AP write or a flush request first issues a DP read of word 3. Its data is returned with `rsp_posted`=1 if it ended OK. A flush with nothing outstanding completes with OK and no raw transaction.
- R8: Every write to DP word 2 (the selection register), whether inserted or requested, loads the cache. The cache is marked known only if that write ended with status OK (00).
- R9: `invalidate` clears the cache to zero and marks the AP part unknown. The DP bank field is marked known, so a newer-mode DP read of word 0 in bank 0 needs no selection write.
- R10: `req_ready` is high only when the block is idle. Each accepted request produces exactly one `rsp_valid` pulse. The status codes are OK=00, WAIT=01 and FAULT=10.
- R11: A WAIT or FAULT on an inserted transaction ends the request with that status, and no further raw transaction is issued for it. A failed selection write leaves the cache unknown.
- R12: The raw transactions of one request go out in this order: collect, then select, then the access. Each raw transaction holds its fields steady until `txn_done`.
- R13: After reset the cache is unknown, so the first banked access issues a selection write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_v6 | input | 1 | 1 = newer architecture, in which DP words 0 and 1 are banked |
| invalidate | input | 1 | Line-reset indication; clears the select cache |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_flush | input | 1 | End-of-batch flush request |
| req_idx | input | 6 | Bank [5:2] and word [1:0] |
| req_apnum | input | 8 | AP number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | OK=00, WAIT=01, FAULT=10 |
| rsp_rdata | output | 32 | Read or collected data |
| rsp_posted | output | 1 | `rsp_rdata` holds a collected AP read result |
| txn_valid | output | 1 | Raw transaction presented |
| txn_write | output | 1 | Raw write |
| txn_ap | output | 1 | Raw AP access |
| txn_addr | output | 2 | Raw word index |
| txn_wdata | output | 32 | Raw write data |
| txn_done | input | 1 | Raw transaction completed this cycle |
| txn_status | input | 2 | Raw completion status |
| txn_rdata | input | 32 | Raw read data |

## Verification
The first raw transaction appears one cycle after a request is accepted. Each following raw transaction appears one cycle after the `txn_done` that ends the one before it. The response pulse follows the final `txn_done` by one cycle, or follows acceptance by one cycle when there is nothing to issue. The bench's downstream responder completes each transaction after a chosen latency, from zero to several cycles. It compares the presented fields against a predicted queue at the moment it signals completion. The responses are sampled on falling edges and compared in order against a second predicted queue. The requester waits for each response before it sends the next request, so every expectation is tied to a definite cycle.

// File: rtl/dpsel_pkg.sv
`timescale 1ns/1ps
package dpsel_pkg;
    localparam logic [1:0] ST_OK    = 2'b00;
    localparam logic [1:0] ST_WAIT  = 2'b01;
    localparam logic [1:0] ST_FAULT = 2'b10;

    // DP word indices whose meaning the sequencer depends on
    localparam logic [1:0] W_ABORT  = 2'd0;
    localparam logic [1:0] W_BANKED = 2'd1;
    localparam logic [1:0] W_SELECT = 2'd2;
    localparam logic [1:0] W_RDBUF  = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FLUSH = 2'd1,
        S_SEL   = 2'd2,
        S_MAIN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dpsel_plan.sv
`timescale 1ns/1ps
module dpsel_plan #(
    parameter int DATA_W = 32,
    parameter int AP_W   = 8,
    parameter int BANK_W = 4,
    parameter int REG_W  = 2
) (
    input  logic                      mode_v6,
    input  logic                      is_ap,
    input  logic                      is_write,
    input  logic [BANK_W+REG_W-1:0]   idx,
    input  logic [AP_W-1:0]           apnum,
    input  logic [DATA_W-1:0]         cache,
    input  logic                      ap_known,
    input  logic                      dp_known,
    output logic                      need_sel,
    output logic [DATA_W-1:0]         sel_value
);
    import dpsel_pkg::*;

    localparam int FLD_W = DATA_W - BANK_W;

    logic [REG_W-1:0]  word;
    logic [BANK_W-1:0] bank;
    logic              dp_banked;
    logic [FLD_W-1:0]  ap_fld;

    assign word = idx[REG_W-1:0];
    assign bank = idx[BANK_W+REG_W-1:REG_W];

    always_comb begin
        if (is_write && word == W_ABORT)
            dp_banked = 1'b0;
        else if (mode_v6)
            dp_banked = (word == W_ABORT) || (word == W_BANKED);
        else
            dp_banked = (word == W_BANKED);
    end

    always_comb begin
        ap_fld = '0;
        ap_fld[FLD_W-1 -: AP_W] = apnum;
        ap_fld[BANK_W-1:0]      = bank;
    end

    always_comb begin
        need_sel  = 1'b0;
        sel_value = cache;
        if (is_ap) begin
            need_sel  = !ap_known || (cache[DATA_W-1:BANK_W] != ap_fld);
            sel_value = {ap_fld, cache[BANK_W-1:0]};
        end else if (dp_banked) begin
            need_sel  = !dp_known || (cache[BANK_W-1:0] != bank);
            sel_value = {cache[DATA_W-1:BANK_W], bank};
        end
    end
endmodule

// File: rtl/dpsel_cache.sv
`timescale 1ns/1ps
module dpsel_cache #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              wr_ok,
    output logic [DATA_W-1:0] cache,
    output logic              ap_known,
    output logic              dp_known
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              apk;
        logic              dpk;
    } cache_t;

    cache_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (invalidate) begin
            c_d.value = '0;
            c_d.apk   = 1'b0;
            c_d.dpk   = 1'b1;
        end else if (wr_en) begin
            c_d.value = wr_value;
            c_d.apk   = wr_ok;
            c_d.dpk   = wr_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cache    = c_q.value;
    assign ap_known = c_q.apk;
    assign dp_known = c_q.dpk;

    p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(invalidate && rst_n) |-> (cache == '0 && !ap_known && dp_known));

    p_sel_ok_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_ok && !invalidate && rst_n)
            |-> (ap_known && dp_known && cache == $past(wr_value)));

    p_sel_bad_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !wr_ok && !invalidate && rst_n) |-> (!ap_known && !dp_known));
endmodule

// File: rtl/dpsel_seq.sv
`timescale 1ns/1ps
module dpsel_seq #(
    parameter int DATA_W = 32,
    parameter int AP_W   = 8,
    parameter int IDX_W  = 6,
    parameter int REG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_ap,
    input  logic              req_flush,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [AP_W-1:0]   req_apnum,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_posted,
    output logic              txn_valid,
    output logic              txn_write,
    output logic              txn_ap,
    output logic [REG_W-1:0]  txn_addr,
    output logic [DATA_W-1:0] txn_wdata,
    input  logic              txn_done,
    input  logic [1:0]        txn_status,
    input  logic [DATA_W-1:0] txn_rdata,
    output logic              pl_ap,
    output logic              pl_write,
    output logic [IDX_W-1:0]  pl_idx,
    output logic [AP_W-1:0]   pl_apnum,
    input  logic              need_sel,
    input  logic [DATA_W-1:0] sel_value
);
    import dpsel_pkg::*;

    typedef struct packed {
        seq_state_e        st;
        logic              w;
        logic              ap;
        logic              fl;
        logic [IDX_W-1:0]  idx;
        logic [AP_W-1:0]   apnum;
        logic [DATA_W-1:0] wdata;
        logic              pending;
        logic [DATA_W-1:0] rdata;
        logic              posted;
        logic [1:0]        status;
        logic              rsp_v;
    } seq_t;

    seq_t s_d, s_q;
    logic ok;

    assign ok = (txn_status == ST_OK);

    // Planner looks at the live request while idle, at the held one otherwise
    always_comb begin
        if (s_q.st == S_IDLE) begin
            pl_ap    = req_ap;
            pl_write = req_write;
            pl_idx   = req_idx;
            pl_apnum = req_apnum;
        end else begin
            pl_ap    = s_q.ap;
            pl_write = s_q.w;
            pl_idx   = s_q.idx;
            pl_apnum = s_q.apnum;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    s_d.w      = req_write;
                    s_d.ap     = req_ap;
                    s_d.fl     = req_flush;
                    s_d.idx    = req_idx;
                    s_d.apnum  = req_apnum;
                    s_d.wdata  = req_wdata;
                    s_d.rdata  = '0;
                    s_d.posted = 1'b0;
                    s_d.status = ST_OK;
                    if ((req_flush || req_write) && s_q.pending)
                        s_d.st = S_FLUSH;
                    else if (req_flush)
                        s_d.rsp_v = 1'b1;
                    else if (need_sel)
                        s_d.st = S_SEL;
                    else
                        s_d.st = S_MAIN;
                end
            end
            S_FLUSH: begin
                if (txn_done) begin
                    s_d.pending = 1'b0;
                    s_d.rdata   = txn_rdata;
                    s_d.posted  = ok;
                    if (!ok || s_q.fl) begin
                        s_d.st     = S_IDLE;
                        s_d.rsp_v  = 1'b1;
                        s_d.status = txn_status;
                    end else if (need_sel) begin
                        s_d.st = S_SEL;
                    end else begin
                        s_d.st = S_MAIN;
                    end
                end
            end
            S_SEL: begin
                if (txn_done) begin
                    if (!ok) begin
                        s_d.st     = S_IDLE;
                        s_d.rsp_v  = 1'b1;
                        s_d.status = txn_status;
                    end else begin
                        s_d.st = S_MAIN;
                    end
                end
            end
            S_MAIN: begin
                if (txn_done) begin
                    if (!s_q.w)
                        s_d.rdata = txn_rdata;
                    if (s_q.ap && !s_q.w) begin
                        s_d.posted  = s_q.pending && ok;
                        s_d.pending = ok;
                    end else if (!s_q.ap && !s_q.w && s_q.idx[REG_W-1:0] == W_RDBUF) begin
                        s_d.posted  = s_q.pending && ok;
                        s_d.pending = 1'b0;
                    end
                    s_d.st     = S_IDLE;
                    s_d.rsp_v  = 1'b1;
                    s_d.status = txn_status;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        txn_valid = 1'b0;
        txn_write = 1'b0;
        txn_ap    = 1'b0;
        txn_addr  = '0;
        txn_wdata = '0;
        case (s_q.st)
            S_FLUSH: begin
                txn_valid = 1'b1;
                txn_addr  = W_RDBUF;
            end
            S_SEL: begin
                txn_valid = 1'b1;
                txn_write = 1'b1;
                txn_addr  = W_SELECT;
                txn_wdata = sel_value;
            end
            S_MAIN: begin
                txn_valid = 1'b1;
                txn_write = s_q.w;
                txn_ap    = s_q.ap;
                txn_addr  = s_q.idx[REG_W-1:0];
                txn_wdata = s_q.w ? s_q.wdata : '0;
            end
            default: ;
        endcase
    end

    assign req_ready  = (s_q.st == S_IDLE);
    assign rsp_valid  = s_q.rsp_v;
    assign rsp_status = s_q.status;
    assign rsp_rdata  = s_q.rdata;
    assign rsp_posted = s_q.posted;

    p_busy_until_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || rsp_valid));

    p_abort_no_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_write && !txn_ap && txn_addr == W_SELECT && s_q.st == S_SEL)
            |-> !(!s_q.ap && s_q.w && s_q.idx[REG_W-1:0] == W_ABORT));

    p_collect_before_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_SEL && s_q.w) |-> !s_q.pending);

    p_txn_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_done) |=>
            (txn_valid && $stable(txn_addr) && $stable(txn_write) && $stable(txn_ap)));
endmodule

// File: rtl/dpsel_sequencer.sv
`timescale 1ns/1ps
module dpsel_sequencer #(
    parameter int DATA_W = 32,
    parameter int AP_W   = 8,
    parameter int BANK_W = 4,
    parameter int REG_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_v6,
    input  logic                      invalidate,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic                      req_ap,
    input  logic                      req_flush,
    input  logic [BANK_W+REG_W-1:0]   req_idx,
    input  logic [AP_W-1:0]           req_apnum,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_status,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_posted,
    output logic                      txn_valid,
    output logic                      txn_write,
    output logic                      txn_ap,
    output logic [REG_W-1:0]          txn_addr,
    output logic [DATA_W-1:0]         txn_wdata,
    input  logic                      txn_done,
    input  logic [1:0]                txn_status,
    input  logic [DATA_W-1:0]         txn_rdata
);
    import dpsel_pkg::*;

    localparam int IDX_W = BANK_W + REG_W;

    logic [DATA_W-1:0] cache;
    logic              ap_known, dp_known;
    logic              pl_ap, pl_write;
    logic [IDX_W-1:0]  pl_idx;
    logic [AP_W-1:0]   pl_apnum;
    logic              need_sel;
    logic [DATA_W-1:0] sel_value;
    logic              sel_wr;

    // Any completed DP write to the selection word refreshes the cache
    assign sel_wr = txn_valid && txn_done && txn_write && !txn_ap && (txn_addr == W_SELECT);

    dpsel_cache #(.DATA_W(DATA_W)) cache_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (invalidate),
        .wr_en      (sel_wr),
        .wr_value   (txn_wdata),
        .wr_ok      (txn_status == ST_OK),
        .cache      (cache),
        .ap_known   (ap_known),
        .dp_known   (dp_known)
    );

    dpsel_plan #(.DATA_W(DATA_W), .AP_W(AP_W), .BANK_W(BANK_W), .REG_W(REG_W)) plan_i (
        .mode_v6   (mode_v6),
        .is_ap     (pl_ap),
        .is_write  (pl_write),
        .idx       (pl_idx),
        .apnum     (pl_apnum),
        .cache     (cache),
        .ap_known  (ap_known),
        .dp_known  (dp_known),
        .need_sel  (need_sel),
        .sel_value (sel_value)
    );

    dpsel_seq #(.DATA_W(DATA_W), .AP_W(AP_W), .IDX_W(IDX_W), .REG_W(REG_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_ap     (req_ap),
        .req_flush  (req_flush),
        .req_idx    (req_idx),
        .req_apnum  (req_apnum),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata),
        .rsp_posted (rsp_posted),
        .txn_valid  (txn_valid),
        .txn_write  (txn_write),
        .txn_ap     (txn_ap),
        .txn_addr   (txn_addr),
        .txn_wdata  (txn_wdata),
        .txn_done   (txn_done),
        .txn_status (txn_status),
        .txn_rdata  (txn_rdata),
        .pl_ap      (pl_ap),
        .pl_write   (pl_write),
        .pl_idx     (pl_idx),
        .pl_apnum   (pl_apnum),
        .need_sel   (need_sel),
        .sel_value  (sel_value)
    );
endmodule

// File: tb/dpsel_sequencer_tb_top.sv
`timescale 1ns/1ps
module dpsel_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_v6 = 1'b0;
    logic        invalidate = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_ap = 1'b0;
    logic        req_flush = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [7:0]  req_apnum = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        rsp_posted;
    logic        txn_valid, txn_write, txn_ap;
    logic [1:0]  txn_addr;
    logic [31:0] txn_wdata;
    logic        txn_done = 1'b0;
    logic [1:0]  txn_status = 2'b00;
    logic [31:0] txn_rdata = '0;

    always #4 clk = ~clk;

    dpsel_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .mode_v6(mode_v6), .invalidate(invalidate),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_ap(req_ap), .req_flush(req_flush), .req_idx(req_idx),
        .req_apnum(req_apnum), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .rsp_posted(rsp_posted), .txn_valid(txn_valid), .txn_write(txn_write),
        .txn_ap(txn_ap), .txn_addr(txn_addr), .txn_wdata(txn_wdata),
        .txn_done(txn_done), .txn_status(txn_status), .txn_rdata(txn_rdata)
    );

    int checks = 0;
    int failures = 0;
    string cur_tag = "R10";
    int lat = 0;
    int inj_idx = -1;
    logic [1:0] inj_st = 2'b00;
    int rsp_seen = 0;
    int rsp_sent = 0;

    logic [35:0] exp_txn[$];
    logic [34:0] exp_rsp[$];

    // reference model state
    logic [31:0] m_cache = '0;
    logic        m_apk = 1'b0, m_dpk = 1'b0, m_pend = 1'b0;
    logic [31:0] m_rd = 32'hC0DE_0000;
    int          m_idx = 0;

    function automatic logic [1:0] st_for(int i);
        return (i == inj_idx) ? inj_st : 2'b00;
    endfunction

    task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic model_req(bit w, bit ap, bit fl, logic [5:0] idx, logic [7:0] apn, logic [31:0] wd);
        logic [31:0] rdat = '0;
        logic        pst = 1'b0;
        logic [1:0]  st = 2'b00;
        logic [1:0]  s;
        bit          done = 0;
        bit          banked, need;
        logic [31:0] val;
        logic [1:0]  word = idx[1:0];
        logic [3:0]  bank = idx[5:2];
        if ((fl || w) && m_pend) begin
            exp_txn.push_back({1'b0, 1'b0, 2'd3, 32'h0});
            s = st_for(m_idx); m_idx++;
            rdat = m_rd; m_rd++;
            m_pend = 1'b0;
            pst = (s == 2'b00);
            if (s != 2'b00 || fl) begin st = s; done = 1; end
        end else if (fl) done = 1;
        if (!done) begin
            need = 0; val = m_cache;
            if (ap) begin
                val  = {apn, 16'h0, bank, m_cache[3:0]};
                need = !m_apk || (m_cache[31:4] != val[31:4]);
            end else begin
                banked = (w && word == 2'd0) ? 1'b0 :
                         (mode_v6 ? (word <= 2'd1) : (word == 2'd1));
                if (banked) begin
                    val  = {m_cache[31:4], bank};
                    need = !m_dpk || (m_cache[3:0] != bank);
                end
            end
            if (need) begin
                exp_txn.push_back({1'b1, 1'b0, 2'd2, val});
                s = st_for(m_idx); m_idx++;
                m_cache = val; m_apk = (s == 2'b00); m_dpk = (s == 2'b00);
                if (s != 2'b00) begin st = s; done = 1; end
            end
        end
        if (!done) begin
            exp_txn.push_back({w, ap, word, w ? wd : 32'h0});
            s = st_for(m_idx); m_idx++;
            if (!w) begin rdat = m_rd; m_rd++; end
            if (w && !ap && word == 2'd2) begin
                m_cache = wd; m_apk = (s == 2'b00); m_dpk = (s == 2'b00);
            end
            if (ap && !w) begin
                pst = m_pend && (s == 2'b00); m_pend = (s == 2'b00);
            end else if (!ap && !w && word == 2'd3) begin
                pst = m_pend && (s == 2'b00); m_pend = 1'b0;
            end
            st = s;
        end
        exp_rsp.push_back({st, pst, rdat});
    endtask

    task automatic do_req(bit w, bit ap, bit fl, logic [5:0] idx, logic [7:0] apn,
                          logic [31:0] wd, int l, int inj_off, logic [1:0] ist, string tag);
        cur_tag = tag;
        lat = l;
        inj_idx = (inj_off < 0) ? -1 : m_idx + inj_off;
        inj_st = ist;
        model_req(w, ap, fl, idx, apn, wd);
        rsp_sent++;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_ap = ap; req_flush = fl;
        req_idx = idx; req_apnum = apn; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid || !req_ready, "R10 ready while busy", {63'h0, req_ready}, 64'h0);
        while (rsp_seen < rsp_sent) @(negedge clk);
        inj_idx = -1;
    endtask

    task automatic do_invalidate();
        @(negedge clk); invalidate = 1'b1;
        @(negedge clk); invalidate = 1'b0;
        m_cache = '0; m_apk = 1'b0; m_dpk = 1'b1;
    endtask

    // downstream responder: also the raw transaction scoreboard
    int resp_idx = 0;
    initial begin
        int cnt = 0;
        logic [35:0] e;
        logic [35:0] a;
        forever begin
            @(negedge clk);
            if (txn_done) begin
                txn_done = 1'b0; cnt = 0;
            end else if (txn_valid) begin
                if (cnt >= lat) begin
                    a = {txn_write, txn_ap, txn_addr, txn_wdata};
                    if (exp_txn.size() == 0) begin
                        check(0, "R12 unexpected raw transaction", {28'h0, a}, 64'h0);
                    end else begin
                        e = exp_txn.pop_front();
                        check(a == e, "R12 raw transaction", {28'h0, a}, {28'h0, e});
                    end
                    txn_status = (resp_idx == inj_idx) ? inj_st : 2'b00;
                    txn_rdata  = txn_write ? 32'h0 : m_rd_bench;
                    if (!txn_write) m_rd_bench++;
                    resp_idx++;
                    txn_done = 1'b1;
                end else cnt++;
            end
        end
    end
    logic [31:0] m_rd_bench = 32'hC0DE_0000;

    // response monitor
    initial begin
        logic [34:0] e;
        logic [34:0] a;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                a = {rsp_status, rsp_posted, rsp_rdata};
                if (exp_rsp.size() == 0) begin
                    check(0, "R10 unexpected response", {29'h0, a}, 64'h0);
                end else begin
                    e = exp_rsp.pop_front();
                    check(a == e, "response status/posted/data", {29'h0, a}, {29'h0, e});
                end
                rsp_seen++;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        cur_tag = "watchdog";
        check(0, "run did not finish", 64'h0, 64'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R10";
        check(req_ready && !rsp_valid && !txn_valid, "reset state",
              {61'h0, req_ready, rsp_valid, txn_valid}, 64'h4);

        // ADIv5-style mode
        do_req(0, 0, 0, 6'h01, 8'h00, 32'h0, 1, -1, 2'b00, "R13");      // first banked DP read selects
        do_req(0, 0, 0, 6'h05, 8'h00, 32'h0, 0, -1, 2'b00, "R2");       // bank 1 -> select bank field
        do_req(0, 0, 0, 6'h05, 8'h00, 32'h0, 2, -1, 2'b00, "R4");       // same bank, no select
        do_req(0, 0, 0, 6'h08, 8'h00, 32'h0, 0, -1, 2'b00, "R1");       // word 0 not banked in this mode
        do_req(0, 1, 0, 6'h07, 8'h03, 32'h0, 1, -1, 2'b00, "R3");       // AP select value
        do_req(0, 1, 0, 6'h05, 8'h03, 32'h0, 0, -1, 2'b00, "R6");       // posted result returned
        do_req(1, 1, 0, 6'h04, 8'h03, 32'h1234_5678, 3, -1, 2'b00, "R7"); // collect before AP write
        do_req(0, 1, 0, 6'h00, 8'h03, 32'h0, 0, -1, 2'b00, "R3");       // AP bank 0

        // newer mode
        mode_v6 = 1'b1;
        do_req(1, 0, 0, 6'h00, 8'h00, 32'h0000_001E, 1, -1, 2'b00, "R5"); // abort: collect, no select
        do_req(0, 0, 0, 6'h00, 8'h00, 32'h0, 0, -1, 2'b00, "R1");       // word 0 banked now
        do_invalidate();
        do_req(0, 0, 0, 6'h00, 8'h00, 32'h0, 0, -1, 2'b00, "R9");       // no select after invalidate
        do_req(0, 1, 0, 6'h01, 8'h05, 32'h0, 2, -1, 2'b00, "R9");       // AP part unknown
        do_req(0, 0, 1, 6'h00, 8'h00, 32'h0, 0, -1, 2'b00, "R7");       // flush collects
        do_req(0, 0, 1, 6'h00, 8'h00, 32'h0, 0, -1, 2'b00, "R7");       // flush, nothing outstanding
        do_req(0, 0, 0, 6'h05, 8'h00, 32'h0, 1, 0, 2'b01, "R11");       // select WAIT
        do_req(0, 0, 0, 6'h05, 8'h00, 32'h0, 0, -1, 2'b00, "R11");      // cache unknown -> reselect
        do_req(1, 0, 0, 6'h02, 8'h00, 32'h0700_0023, 0, -1, 2'b00, "R8"); // direct select write
        do_req(0, 1, 0, 6'h09, 8'h07, 32'h0, 1, -1, 2'b00, "R8");       // matches loaded cache
        do_req(0, 0, 0, 6'h03, 8'h00, 32'h0, 0, -1, 2'b00, "R6");       // buffer read collects
        do_req(0, 1, 0, 6'h09, 8'h07, 32'h0, 0, 0, 2'b10, "R6");        // AP read FAULT
        do_req(1, 1, 0, 6'h08, 8'h07, 32'hAAAA_5555, 0, -1, 2'b00, "R6"); // nothing to collect
        do_req(0, 1, 0, 6'h09, 8'h07, 32'h0, 0, -1, 2'b00, "R12");
        do_req(1, 0, 0, 6'h01, 8'h00, 32'h0000_00FF, 1, 0, 2'b10, "R11"); // collect FAULT ends it
        do_req(1, 0, 0, 6'h01, 8'h00, 32'h0000_00FF, 0, -1, 2'b00, "R12");

        repeat (4) @(negedge clk);
        cur_tag = "R12";
        check(exp_txn.size() == 0 && exp_rsp.size() == 0, "leftover expectations",
              {32'h0, exp_txn.size()}, 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule